// File: doc/BRIEF.md
# Debug Breakpoint Unit

This block watches a 32-bit core's instruction fetches and its loads and stores, and raises a debug exception when one of them lands on an armed breakpoint. It holds a small set of instruction breakpoints, each an exact address with an enable bit. It also holds a set of data breakpoints, each a base address and a control word. The control word carries a low-order address mask field and two arming bits, one for reads and one for writes.

All breakpoint state and the processor status word are written through one special-register write port. Hit detection is combinational, so a data breakpoint can cancel the access in the same cycle it is presented. A debug exception is taken only when the interrupt level in the status word is below the configured debug level. When it is taken, the unit records the cause and the faulting PC, keeps a copy of the old status word, and raises the status word to the debug level with the exception-mode bit set. All of this happens on the next clock edge.

Top module: `dbg_brk_unit`

## Requirements
- R1: Writing the instruction-breakpoint enable register (select code 0) keeps only bits [N_IBRK-1:0] of the written value, as seen on `ibrk_en_o`; higher written bits are dropped.
- R2: Instruction breakpoint i hits when `fetch_valid` is high, enable bit i is set and `fetch_pc` equals its address (select code 1, entry chosen by `sr_idx`); any other fetch address does not hit.
- R3: A data breakpoint's effective mask is its control word's field [5:0] with all bits [31:6] forced to one. Access address A hits base address B when (A & mask) == (B & mask), which covers (~mask)+1 bytes. Base addresses use select code 2 and control words select code 3.
- R4: When the inverted effective mask is not of the form 2^k-1, the mask becomes ones in exactly its leading-ones count of high bits and zeros below. For example, field 6'b101100 covers a 32-byte range.
- R5: Control bit 30 arms a data breakpoint for writes (`mem_write`=1) and bit 31 arms it for reads (`mem_write`=0); with neither bit set the entry never hits.
- R6: A taken data-breakpoint hit drives `dbg_cancel_o` high combinationally, in the same cycle the access is presented.
- R7: A debug exception is taken (`dbg_hit_o`) only while status field [3:0] is below DEBUG_LEVEL (6); otherwise hits are ignored and no state changes.
- R8: At the clock edge of a taken exception, `dbg_eps_o` gets the old status word. The status word gets field [3:0] = 6 and bit 4 = 1, with its other bits kept, and `dbg_epc_o` gets the PC of the reporting source. Reset clears all state.
- R9: Cause encoding: bit 0 is set for an instruction hit and bit 1 for a data hit, and bits [7:4] hold the reporting entry's index. If both sources hit, both bits are set, and the index and PC (`mem_pc`) come from the data side.
- R10: When several entries of one source hit at once, the lowest-numbered entry is reported.
- R11: A status write (select code 4) in the same cycle as a taken exception loses to the exception update. `dbg_cause_o` changes only on a taken exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_we | input | 1 | Special-register write strobe |
| sr_sel | input | 3 | Register select code |
| sr_idx | input | IDX_W | Breakpoint entry index for the write |
| sr_wdata | input | XLEN | Write data |
| fetch_valid | input | 1 | Fetch address valid |
| fetch_pc | input | XLEN | Fetch address |
| mem_valid | input | 1 | Load/store valid |
| mem_write | input | 1 | 1 = store, 0 = load |
| mem_addr | input | XLEN | Load/store address |
| mem_pc | input | XLEN | PC of the load/store instruction |
| ibrk_en_o | output | N_IBRK | Instruction-breakpoint enables |
| dbg_hit_o | output | 1 | Debug exception taken this cycle |
| dbg_cancel_o | output | 1 | Cancel current load/store |
| dbg_cause_o | output | 8 | Debug cause |
| dbg_epc_o | output | XLEN | Saved PC for the debug level |
| dbg_eps_o | output | XLEN | Saved status for the debug level |
| ps_o | output | XLEN | Current status word |

## Verification
`dbg_hit_o` and `dbg_cancel_o` are combinational and are due in the same cycle as the fetch or access. Cause, saved PC, saved status and the new status word are due one clock edge later, and register writes show one edge after the strobe. The bench drives inputs on the falling edge and checks the combinational outputs 1 ns later. It checks the registered results at the next falling edge, after exactly one rising edge. A reference model computes the expected mask by counting leading ones, and sums hits across randomised configurations and interrupt levels.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
    typedef enum logic [2:0] {
        SR_IBRK_EN   = 3'd0,
        SR_IBRK_ADDR = 3'd1,
        SR_DBRK_ADDR = 3'd2,
        SR_DBRK_CTRL = 3'd3,
        SR_PS        = 3'd4
    } sr_sel_e;

    localparam int PS_LVL_LSB    = 0;
    localparam int PS_LVL_W      = 4;
    localparam int PS_EXCM_BIT   = 4;
    localparam int CTL_SB_BIT    = 30;
    localparam int CTL_LB_BIT    = 31;
    localparam int CAUSE_W       = 8;
    localparam int CAUSE_IDX_LSB = 4;
    localparam int CAUSE_IDX_W   = 4;
endpackage

// File: rtl/dbg_ibrk_cmp.sv
module dbg_ibrk_cmp #(
    parameter int XLEN = 32,
    parameter int N    = 2
) (
    input  logic                     valid,
    input  logic [XLEN-1:0]          pc,
    input  logic [N-1:0]             en,
    input  logic [N-1:0][XLEN-1:0]   addr,
    output logic [N-1:0]             hit
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        assign hit[g] = valid && en[g] && (pc == addr[g]);
    end
endmodule

// File: rtl/dbg_dbrk_cmp.sv
module dbg_dbrk_cmp #(
    parameter int XLEN   = 32,
    parameter int N      = 2,
    parameter int MASK_W = 6
) (
    input  logic                     valid,
    input  logic                     write,
    input  logic [XLEN-1:0]          addr,
    input  logic [N-1:0][XLEN-1:0]   base,
    input  logic [N-1:0][MASK_W-1:0] mask_lo,
    input  logic [N-1:0]             arm_st,
    input  logic [N-1:0]             arm_ld,
    output logic [N-1:0]             hit
);
    localparam int HI_W = XLEN - MASK_W;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [XLEN-1:0] full_mask;
        logic            armed;
        assign full_mask = {{HI_W{1'b1}}, mask_lo[g]};
        assign armed     = write ? arm_st[g] : arm_ld[g];
        assign hit[g]    = valid && armed &&
                           ((addr & full_mask) == (base[g] & full_mask));
    end
endmodule

// File: rtl/dbg_first_set.sv
module dbg_first_set #(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
    import dbg_brk_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int N_IBRK      = 2,
    parameter int N_DBRK      = 2,
    parameter int MASK_W      = 6,
    parameter int DEBUG_LEVEL = 6,
    localparam int NMAX       = (N_IBRK > N_DBRK) ? N_IBRK : N_DBRK,
    localparam int IDX_W      = (NMAX > 1) ? $clog2(NMAX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sr_we,
    input  logic [2:0]          sr_sel,
    input  logic [IDX_W-1:0]    sr_idx,
    input  logic [XLEN-1:0]     sr_wdata,
    input  logic                fetch_valid,
    input  logic [XLEN-1:0]     fetch_pc,
    input  logic                mem_valid,
    input  logic                mem_write,
    input  logic [XLEN-1:0]     mem_addr,
    input  logic [XLEN-1:0]     mem_pc,
    output logic [N_IBRK-1:0]   ibrk_en_o,
    output logic                dbg_hit_o,
    output logic                dbg_cancel_o,
    output logic [CAUSE_W-1:0]  dbg_cause_o,
    output logic [XLEN-1:0]     dbg_epc_o,
    output logic [XLEN-1:0]     dbg_eps_o,
    output logic [XLEN-1:0]     ps_o
);
    typedef struct packed {
        logic [N_IBRK-1:0]             ien;
        logic [N_IBRK-1:0][XLEN-1:0]   iaddr;
        logic [N_DBRK-1:0][XLEN-1:0]   daddr;
        logic [N_DBRK-1:0][MASK_W-1:0] dmask;
        logic [N_DBRK-1:0]             dst;
        logic [N_DBRK-1:0]             dld;
        logic [XLEN-1:0]               ps;
        logic [XLEN-1:0]               epc;
        logic [XLEN-1:0]               eps;
        logic [CAUSE_W-1:0]            cause;
    } state_t;

    state_t st_d, st_q;

    // Keep only the leading run of ones of the field; upper bits are ones.
    function automatic logic [MASK_W-1:0] trim_mask(input logic [MASK_W-1:0] f);
        logic run;
        run = 1'b1;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            run          = run & f[i];
            trim_mask[i] = run;
        end
    endfunction

    logic [N_IBRK-1:0] i_hit;
    logic [N_DBRK-1:0] d_hit;
    logic              i_any, d_any, lvl_ok, take;
    logic [IDX_W-1:0]  i_idx, d_idx;

    dbg_ibrk_cmp #(.XLEN(XLEN), .N(N_IBRK)) u_icmp (
        .valid (fetch_valid),
        .pc    (fetch_pc),
        .en    (st_q.ien),
        .addr  (st_q.iaddr),
        .hit   (i_hit)
    );

    dbg_dbrk_cmp #(.XLEN(XLEN), .N(N_DBRK), .MASK_W(MASK_W)) u_dcmp (
        .valid   (mem_valid),
        .write   (mem_write),
        .addr    (mem_addr),
        .base    (st_q.daddr),
        .mask_lo (st_q.dmask),
        .arm_st  (st_q.dst),
        .arm_ld  (st_q.dld),
        .hit     (d_hit)
    );

    dbg_first_set #(.N(N_IBRK), .IW(IDX_W)) u_ipick (
        .req (i_hit), .any (i_any), .idx (i_idx)
    );

    dbg_first_set #(.N(N_DBRK), .IW(IDX_W)) u_dpick (
        .req (d_hit), .any (d_any), .idx (d_idx)
    );

    assign lvl_ok = st_q.ps[PS_LVL_LSB +: PS_LVL_W] < PS_LVL_W'(DEBUG_LEVEL);
    assign take   = lvl_ok && (i_any || d_any);

    always_comb begin
        st_d = st_q;
        if (sr_we) begin
            case (sr_sel)
                SR_IBRK_EN:   st_d.ien = sr_wdata[N_IBRK-1:0];
                SR_IBRK_ADDR: st_d.iaddr[sr_idx] = sr_wdata;
                SR_DBRK_ADDR: st_d.daddr[sr_idx] = sr_wdata;
                SR_DBRK_CTRL: begin
                    st_d.dmask[sr_idx] = trim_mask(sr_wdata[MASK_W-1:0]);
                    st_d.dst[sr_idx]   = sr_wdata[CTL_SB_BIT];
                    st_d.dld[sr_idx]   = sr_wdata[CTL_LB_BIT];
                end
                SR_PS:        st_d.ps = sr_wdata;
                default:      ;
            endcase
        end
        if (take) begin
            st_d.cause    = '0;
            st_d.cause[0] = i_any;
            st_d.cause[1] = d_any;
            st_d.cause[CAUSE_IDX_LSB +: CAUSE_IDX_W] =
                CAUSE_IDX_W'(d_any ? d_idx : i_idx);
            st_d.epc = d_any ? mem_pc : fetch_pc;
            st_d.eps = st_q.ps;
            st_d.ps  = st_q.ps;
            st_d.ps[PS_LVL_LSB +: PS_LVL_W] = PS_LVL_W'(DEBUG_LEVEL);
            st_d.ps[PS_EXCM_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ibrk_en_o    = st_q.ien;
    assign dbg_hit_o    = take;
    assign dbg_cancel_o = lvl_ok && d_any;
    assign dbg_cause_o  = st_q.cause;
    assign dbg_epc_o    = st_q.epc;
    assign dbg_eps_o    = st_q.eps;
    assign ps_o         = st_q.ps;
endmodule

// File: rtl/dbg_brk_unit_chk.sv
module dbg_brk_unit_chk
    import dbg_brk_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int N_IBRK      = 2,
    parameter int DEBUG_LEVEL = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sr_we,
    input logic [2:0]         sr_sel,
    input logic [XLEN-1:0]    sr_wdata,
    input logic               mem_valid,
    input logic [N_IBRK-1:0]  ibrk_en_o,
    input logic               dbg_hit_o,
    input logic               dbg_cancel_o,
    input logic [CAUSE_W-1:0] dbg_cause_o,
    input logic [XLEN-1:0]    dbg_eps_o,
    input logic [XLEN-1:0]    ps_o
);
    a_r1_en_trim: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_we && sr_sel == SR_IBRK_EN) |=> ibrk_en_o == $past(sr_wdata[N_IBRK-1:0]));

    a_r6_cancel_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_cancel_o |-> (mem_valid && dbg_hit_o));

    a_r7_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hit_o |-> (ps_o[PS_LVL_W-1:0] < PS_LVL_W'(DEBUG_LEVEL)));

    a_r8_ps_raised: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hit_o |=> (ps_o[PS_EXCM_BIT] && ps_o[PS_LVL_W-1:0] == PS_LVL_W'(DEBUG_LEVEL)));

    a_r8_eps_saved: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hit_o |=> dbg_eps_o == $past(ps_o));

    a_r9_cause_source: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_hit_o |=> dbg_cause_o[1:0] != 2'b00);

    a_r11_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_hit_o |=> $stable(dbg_cause_o));
endmodule

bind dbg_brk_unit dbg_brk_unit_chk #(
    .XLEN(XLEN), .N_IBRK(N_IBRK), .DEBUG_LEVEL(DEBUG_LEVEL)
) u_chk (.*);

// File: tb/dbg_brk_unit_bench.sv
`timescale 1ns/1ps
module dbg_brk_unit_bench;
    import dbg_brk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_we = 1'b0;
    logic [2:0]  sr_sel = 3'd0;
    logic [0:0]  sr_idx = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        mem_valid = 1'b0;
    logic        mem_write = 1'b0;
    logic [31:0] mem_addr = '0;
    logic [31:0] mem_pc = '0;
    logic [1:0]  ibrk_en_o;
    logic        dbg_hit_o, dbg_cancel_o;
    logic [7:0]  dbg_cause_o;
    logic [31:0] dbg_epc_o, dbg_eps_o, ps_o;

    int total = 0;
    int bad   = 0;

    logic [31:0] s_iaddr [2];
    logic [31:0] s_daddr [2];
    logic [5:0]  s_dfld  [2];
    logic        s_st    [2];
    logic        s_ld    [2];
    logic [1:0]  s_ien = '0;
    logic [31:0] s_ps = '0, s_epc = '0, s_eps = '0;
    logic [7:0]  s_cause = '0;

    always #4 clk = ~clk;

    dbg_brk_unit u_dbg_brk_unit (
        .clk, .rst_n, .sr_we, .sr_sel, .sr_idx, .sr_wdata,
        .fetch_valid, .fetch_pc, .mem_valid, .mem_write, .mem_addr, .mem_pc,
        .ibrk_en_o, .dbg_hit_o, .dbg_cancel_o, .dbg_cause_o,
        .dbg_epc_o, .dbg_eps_o, .ps_o
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Mask model: count leading ones of the widened field, then rebuild.
    function automatic logic [31:0] exp_mask(input logic [5:0] f);
        logic [31:0] e;
        int lead;
        e = {26'h3FF_FFFF, f};
        lead = 0;
        for (int i = 31; i >= 0; i--) if (e[i] && lead == 31 - i) lead++;
        exp_mask = '0;
        for (int i = 0; i < 32; i++) if ((31 - i) < lead) exp_mask[i] = 1'b1;
    endfunction

    task automatic sr_write(input logic [2:0] sel, input int idx, input logic [31:0] d);
        @(negedge clk);
        sr_we = 1'b1; sr_sel = sel; sr_idx = 1'(idx); sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
        case (sel)
            SR_IBRK_EN:   s_ien = d[1:0];
            SR_IBRK_ADDR: s_iaddr[idx] = d;
            SR_DBRK_ADDR: s_daddr[idx] = d;
            SR_DBRK_CTRL: begin s_dfld[idx] = d[5:0]; s_st[idx] = d[30]; s_ld[idx] = d[31]; end
            SR_PS:        s_ps = d;
            default:      ;
        endcase
    endtask

    task automatic access(input string tag, input logic fv, input logic [31:0] fpc,
                          input logic mv, input logic mw, input logic [31:0] maddr,
                          input logic [31:0] mpc);
        logic [1:0] ih, dh;
        logic lok, take;
        logic [3:0] idx;
        logic [31:0] m;
        for (int j = 0; j < 2; j++) begin
            m = exp_mask(s_dfld[j]);
            ih[j] = fv && s_ien[j] && (fpc == s_iaddr[j]);
            dh[j] = mv && (mw ? s_st[j] : s_ld[j]) && ((maddr & m) == (s_daddr[j] & m));
        end
        lok  = s_ps[3:0] < 4'd6;
        take = lok && (ih != 0 || dh != 0);
        if (dh != 0) idx = dh[0] ? 4'd0 : 4'd1;
        else         idx = ih[0] ? 4'd0 : 4'd1;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fpc;
        mem_valid = mv; mem_write = mw; mem_addr = maddr; mem_pc = mpc;
        #1;
        chk(tag, "hit", 32'(dbg_hit_o), 32'(take));
        chk("R6", "cancel", 32'(dbg_cancel_o), 32'(lok && dh != 0));
        @(negedge clk);
        if (take) begin
            s_cause = {idx, 2'b00, (dh != 0), (ih != 0)};
            s_epc   = (dh != 0) ? mpc : fpc;
            s_eps   = s_ps;
            s_ps    = (s_ps & ~32'h1F) | 32'h16;
        end
        chk(tag, "cause", 32'(dbg_cause_o), 32'(s_cause));
        chk(tag, "epc", dbg_epc_o, s_epc);
        chk(tag, "eps", dbg_eps_o, s_eps);
        chk(tag, "ps", ps_o, s_ps);
        fetch_valid = 1'b0; mem_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R8 watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] fpc, maddr;
        int j;
        void'($urandom(32'd2024));
        for (int k = 0; k < 2; k++) begin
            s_iaddr[k] = '0; s_daddr[k] = '0; s_dfld[k] = '0; s_st[k] = 0; s_ld[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R8", "reset ps", ps_o, 32'h0);
        chk("R11", "reset cause", 32'(dbg_cause_o), 32'h0);
        chk("R1", "reset en", 32'(ibrk_en_o), 32'h0);

        // R1: enable trimming
        sr_write(SR_IBRK_EN, 0, 32'hFFFF_FFFF);
        chk("R1", "en all", 32'(ibrk_en_o), 32'h3);
        sr_write(SR_IBRK_EN, 0, 32'h0000_0006);
        chk("R1", "en trim", 32'(ibrk_en_o), 32'h2);

        // R2: instruction breakpoints, only entry 1 enabled
        sr_write(SR_IBRK_ADDR, 0, 32'h0000_1000);
        sr_write(SR_IBRK_ADDR, 1, 32'h0000_2000);
        access("R2", 1'b1, 32'h0000_1000, 1'b0, 1'b0, 32'h0, 32'h0);
        access("R2", 1'b1, 32'h0000_2004, 1'b0, 1'b0, 32'h0, 32'h0);
        access("R2", 1'b1, 32'h0000_2000, 1'b0, 1'b0, 32'h0, 32'h0);
        chk("R9", "ibrk idx1 cause", 32'(dbg_cause_o), 32'h11);

        // R10: both entries on the same address
        sr_write(SR_PS, 0, 32'h0);
        sr_write(SR_IBRK_ADDR, 0, 32'h0000_3000);
        sr_write(SR_IBRK_ADDR, 1, 32'h0000_3000);
        sr_write(SR_IBRK_EN, 0, 32'h3);
        access("R10", 1'b1, 32'h0000_3000, 1'b0, 1'b0, 32'h0, 32'h0);
        chk("R10", "lowest idx", 32'(dbg_cause_o), 32'h01);

        // R3: contiguous 8-byte window
        sr_write(SR_PS, 0, 32'h0);
        sr_write(SR_DBRK_ADDR, 0, 32'h4000_0040);
        sr_write(SR_DBRK_CTRL, 0, 32'hC000_0038);
        access("R3", 1'b0, 32'h0, 1'b1, 1'b1, 32'h4000_0047, 32'h0000_0500);
        sr_write(SR_PS, 0, 32'h0);
        access("R3", 1'b0, 32'h0, 1'b1, 1'b1, 32'h4000_0048, 32'h0000_0504);

        // R4: non-contiguous field 101100 -> 32-byte window
        sr_write(SR_DBRK_CTRL, 0, 32'hC000_002C);
        access("R4", 1'b0, 32'h0, 1'b1, 1'b0, 32'h4000_005F, 32'h0000_0600);
        sr_write(SR_PS, 0, 32'h0);
        access("R4", 1'b0, 32'h0, 1'b1, 1'b0, 32'h4000_0060, 32'h0000_0604);

        // R5: arming bits
        sr_write(SR_DBRK_CTRL, 0, 32'h4000_003F);
        access("R5", 1'b0, 32'h0, 1'b1, 1'b0, 32'h4000_0040, 32'h0000_0700);
        access("R5", 1'b0, 32'h0, 1'b1, 1'b1, 32'h4000_0040, 32'h0000_0704);
        sr_write(SR_PS, 0, 32'h0);
        sr_write(SR_DBRK_CTRL, 0, 32'h0000_003F);
        access("R5", 1'b0, 32'h0, 1'b1, 1'b1, 32'h4000_0040, 32'h0000_0708);
        access("R5", 1'b0, 32'h0, 1'b1, 1'b0, 32'h4000_0040, 32'h0000_070C);

        // R7: level gate
        sr_write(SR_DBRK_CTRL, 0, 32'hC000_003F);
        sr_write(SR_PS, 0, 32'h6);
        access("R7", 1'b0, 32'h0, 1'b1, 1'b0, 32'h4000_0040, 32'h0000_0800);
        sr_write(SR_PS, 0, 32'h7);
        access("R7", 1'b0, 32'h0, 1'b1, 1'b0, 32'h4000_0040, 32'h0000_0804);
        sr_write(SR_PS, 0, 32'h5);
        access("R7", 1'b0, 32'h0, 1'b1, 1'b0, 32'h4000_0040, 32'h0000_0808);

        // R8: other status bits kept
        sr_write(SR_PS, 0, 32'hABCD_0002);
        access("R8", 1'b1, 32'h0000_3000, 1'b0, 1'b0, 32'h0, 32'h0);
        chk("R8", "ps keep", ps_o, 32'hABCD_0016);

        // R9: both sources at once
        sr_write(SR_PS, 0, 32'h0);
        sr_write(SR_DBRK_ADDR, 1, 32'h4000_0040);
        sr_write(SR_DBRK_CTRL, 1, 32'hC000_003F);
        sr_write(SR_DBRK_CTRL, 0, 32'h0);
        access("R9", 1'b1, 32'h0000_3000, 1'b1, 1'b1, 32'h4000_0040, 32'h0000_0900);
        chk("R9", "both cause", 32'(dbg_cause_o), 32'h13);
        chk("R9", "both epc", dbg_epc_o, 32'h0000_0900);

        // R11: concurrent status write loses to the exception
        sr_write(SR_PS, 0, 32'h0000_0001);
        @(negedge clk);
        sr_we = 1'b1; sr_sel = SR_PS; sr_idx = 1'b0; sr_wdata = 32'h0000_00A3;
        fetch_valid = 1'b1; fetch_pc = 32'h0000_3000;
        @(negedge clk);
        sr_we = 1'b0; fetch_valid = 1'b0;
        s_eps = s_ps; s_ps = 32'h0000_0016; s_epc = 32'h0000_3000; s_cause = 8'h01;
        chk("R11", "ps race", ps_o, s_ps);
        chk("R11", "cause race", 32'(dbg_cause_o), 32'(s_cause));

        // randomised phase
        for (int it = 0; it < 300; it++) begin
            if (it % 40 == 0) begin
                for (int k = 0; k < 2; k++) begin
                    sr_write(SR_IBRK_ADDR, k, $urandom & 32'hFFFF_FFFC);
                    sr_write(SR_DBRK_ADDR, k, $urandom);
                    sr_write(SR_DBRK_CTRL, k, $urandom);
                end
                sr_write(SR_IBRK_EN, 0, $urandom);
            end
            sr_write(SR_PS, 0, ($urandom & 32'hFFFF_FFE0) | ($urandom % 8));
            j = int'($urandom % 2);
            fpc   = ($urandom % 2 == 0) ? s_iaddr[j] : $urandom;
            maddr = ($urandom % 2 == 0) ? (s_daddr[j] ^ ($urandom & 32'h3F)) : $urandom;
            access("R3", 1'($urandom % 2), fpc, 1'($urandom % 2), 1'($urandom % 2),
                   maddr, $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule